// File: doc/BRIEF.md
# Byte Command Serial Port Decoder

This block is the slave side of a four-wire synchronous serial link (chip select, bit clock, data in, data out). All four lines are sampled by the system clock after a synchronizer and an edge detector. Data in is shifted into an 8-bit receiver, most significant bit first, on every bit clock rising edge while chip select is low. Each completed byte is classified as a register read, a register write, an instruction or a synchronizing byte.

A write command collects a fixed number of data bytes and then issues a one-cycle write strobe with the address and the assembled word to a register file outside the block. A read command issues a one-cycle fetch strobe, captures the returned word and shifts it out on data out. While that word is leaving, the receiver keeps taking bytes: synchronizing fillers, instructions and write traffic run alongside, and a new read replaces the old one. Instructions leave the block as a one-cycle strobe carrying the opcode byte. The register contents and the execution of instructions belong to the surrounding logic.

Top module: `byte_cmd_port`

## Requirements
- R1: After reset, data-out enable is 0, data out is 0, and no write, fetch or instruction strobe is raised until a byte has been received.
- R2: Data in is shifted in MSB first, one bit per bit-clock rising edge, and only while chip select is low. Bit-clock edges while chip select is high have no effect on later bytes.
- R3: Byte encoding: bits 7..6 = 00 is a read of the register at bits 5..1, 01 is a write to the register at bits 5..1 (bit 0 is ignored in both), 11 is an instruction, except 0xFE and 0xFF which are synchronizing bytes. Bits 7..6 = 10 is reserved and ignored. At most one strobe is raised in any cycle.
- R4: After a write command, exactly the next three bytes are data, taken as command-free payload, first byte most significant. After the third, a one-cycle write strobe carries the 5-bit address and the 24-bit word.
- R5: A read command raises a one-cycle fetch strobe with the 5-bit address. The 24-bit word on the read data input, sampled the cycle after the strobe, leaves on data out MSB first. Data out changes only after bit-clock falling edges: the first bit appears after the falling edge that follows the command's eighth rising edge. After the 24th bit, data out is 0.
- R6: A read command that completes while read data is still leaving aborts that stream. The next bit out is the MSB of the newly fetched word.
- R7: Synchronizing bytes 0xFE and 0xFF raise no strobe and do not disturb a read stream in progress.
- R8: An instruction byte raises a one-cycle strobe with the full 8-bit opcode. It does not stop or alter a read stream in progress.
- R9: With chip select high, data-out enable is 0 and data out is 0. Raising chip select clears the bit counter, a partial byte, pending write data and any read stream.
- R10: A write command and its data bytes received during a read stream leave that stream running bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Drive enable for serial data out (high impedance when 0) |
| reg_wr_en_o | output | 1 | One-cycle register write strobe |
| reg_wr_addr_o | output | 5 | Register write address |
| reg_wr_data_o | output | 8*WR_BYTES | Register write word |
| reg_rd_en_o | output | 1 | One-cycle register fetch strobe |
| reg_rd_addr_o | output | 5 | Register fetch address, held until the next read |
| reg_rd_data_i | input | 8*RD_BYTES | Fetched register word |
| instr_valid_o | output | 1 | One-cycle instruction strobe |
| instr_op_o | output | 8 | Instruction opcode byte |

## Verification
Two things can happen on the same byte boundary. A byte can complete and be decoded (instruction, write payload, synchronizing filler or a fresh read) while the transmit shifter is in the middle of a read word. The bench provokes this by sending instruction, write and read commands as the filler bytes of a running read. A behavioural model keeps queues of the expected data-out bits and the expected strobes. It checks every data-out bit just before each rising edge, and it checks each strobe on the clock where it appears. An aborted stream therefore shows up as a wrong bit, and a disturbed stream as a missing or extra strobe.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
   localparam int BYTE_W   = 8;
   localparam int ADDR_W   = 5;
   localparam int ADDR_LSB = 1;

   typedef enum logic [2:0] {
      CMD_READ,
      CMD_WRITE,
      CMD_INSTR,
      CMD_SYNC,
      CMD_RSVD
   } cmd_kind_e;

   // kind field in the top two bits; the two all-ones-high codes are fillers
   function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
      cmd_kind_e k;
      case (b[7:6])
         2'b00:   k = CMD_READ;
         2'b01:   k = CMD_WRITE;
         2'b11:   k = (b[7:1] == 7'h7F) ? CMD_SYNC : CMD_INSTR;
         default: k = CMD_RSVD;
      endcase
      return k;
   endfunction
endpackage

// File: rtl/bcp_sync.sv
module bcp_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] level_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RST_VAL[g]}};
            prev  <= RST_VAL[g];
         end else begin
            chain <= {chain[STAGES-2:0], async_i[g]};
            prev  <= chain[STAGES-1];
         end
      end
      assign level_o[g] = chain[STAGES-1];
      assign rise_o[g]  = chain[STAGES-1] & ~prev;
      assign fall_o[g]  = ~chain[STAGES-1] & prev;
   end
endmodule

// File: rtl/bcp_rx.sv
module bcp_rx
   import bcp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              strobe_i,
   input  logic              bit_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-2:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shreg   <= '0;
         valid_o <= 1'b0;
         byte_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (!enable_i) begin
            cnt <= '0;
         end else if (strobe_i) begin
            shreg <= {shreg[BYTE_W-3:0], bit_i};
            if (cnt == CNT_W'(BYTE_W-1)) begin
               cnt     <= '0;
               valid_o <= 1'b1;
               byte_o  <= {shreg, bit_i};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/bcp_ctrl.sv
module bcp_ctrl
   import bcp_pkg::*;
#(
   parameter int WR_BYTES = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enable_i,
   input  logic                       byte_valid_i,
   input  logic [BYTE_W-1:0]          byte_i,
   output logic                       wr_en_o,
   output logic [ADDR_W-1:0]          wr_addr_o,
   output logic [WR_BYTES*BYTE_W-1:0] wr_data_o,
   output logic                       rd_en_o,
   output logic [ADDR_W-1:0]          rd_addr_o,
   output logic                       tx_load_o,
   output logic                       instr_valid_o,
   output logic [BYTE_W-1:0]          instr_op_o
);
   localparam int WR_W   = WR_BYTES * BYTE_W;
   localparam int LEFT_W = $clog2(WR_BYTES + 1);

   logic              collecting;
   logic [LEFT_W-1:0] left;
   logic [WR_W-1:0]   next_word;
   logic              take;

   assign take = enable_i && byte_valid_i;

   if (WR_BYTES == 1) begin : g_single
      assign next_word = byte_i;
   end else begin : g_multi
      logic [WR_W-BYTE_W-1:0] acc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  acc <= '0;
         else if (take && collecting) acc <= next_word[WR_W-BYTE_W-1:0];
      end
      assign next_word = {acc, byte_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collecting    <= 1'b0;
         left          <= '0;
         wr_en_o       <= 1'b0;
         wr_addr_o     <= '0;
         wr_data_o     <= '0;
         rd_en_o       <= 1'b0;
         rd_addr_o     <= '0;
         tx_load_o     <= 1'b0;
         instr_valid_o <= 1'b0;
         instr_op_o    <= '0;
      end else begin
         wr_en_o       <= 1'b0;
         rd_en_o       <= 1'b0;
         instr_valid_o <= 1'b0;
         tx_load_o     <= rd_en_o;
         if (!enable_i) begin
            collecting <= 1'b0;
            left       <= '0;
         end else if (byte_valid_i) begin
            if (collecting) begin
               left <= left - 1'b1;
               if (left == LEFT_W'(1)) begin
                  collecting <= 1'b0;
                  wr_en_o    <= 1'b1;
                  wr_data_o  <= next_word;
               end
            end else begin
               case (classify(byte_i))
                  CMD_READ: begin
                     rd_en_o   <= 1'b1;
                     rd_addr_o <= byte_i[ADDR_LSB +: ADDR_W];
                  end
                  CMD_WRITE: begin
                     collecting <= 1'b1;
                     left       <= LEFT_W'(WR_BYTES);
                     wr_addr_o  <= byte_i[ADDR_LSB +: ADDR_W];
                  end
                  CMD_INSTR: begin
                     instr_valid_o <= 1'b1;
                     instr_op_o    <= byte_i;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/bcp_tx.sv
module bcp_tx
   import bcp_pkg::*;
#(
   parameter int NBYTES = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     enable_i,
   input  logic                     load_i,
   input  logic [NBYTES*BYTE_W-1:0] data_i,
   input  logic                     shift_i,
   output logic                     sdo_o
);
   localparam int TX_W  = NBYTES * BYTE_W;
   localparam int CNT_W = $clog2(TX_W + 1);

   logic [TX_W-1:0]  sh;
   logic [CNT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         left  <= '0;
         sdo_o <= 1'b0;
      end else if (!enable_i) begin
         sh    <= '0;
         left  <= '0;
         sdo_o <= 1'b0;
      end else if (load_i) begin
         sh   <= data_i;
         left <= CNT_W'(TX_W);
      end else if (shift_i) begin
         if (left != '0) begin
            sdo_o <= sh[TX_W-1];
            sh    <= sh << 1;
            left  <= left - 1'b1;
         end else begin
            sdo_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/byte_cmd_port.sv
module byte_cmd_port
   import bcp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WR_BYTES    = 3,
   parameter int RD_BYTES    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n_i,
   input  logic                       sclk_i,
   input  logic                       sdi_i,
   output logic                       sdo_o,
   output logic                       sdo_oe_o,
   output logic                       reg_wr_en_o,
   output logic [ADDR_W-1:0]          reg_wr_addr_o,
   output logic [WR_BYTES*BYTE_W-1:0] reg_wr_data_o,
   output logic                       reg_rd_en_o,
   output logic [ADDR_W-1:0]          reg_rd_addr_o,
   input  logic [RD_BYTES*BYTE_W-1:0] reg_rd_data_i,
   output logic                       instr_valid_o,
   output logic [BYTE_W-1:0]          instr_op_o
);
   initial begin
      if (SYNC_STAGES < 2)                $error("SYNC_STAGES must be at least 2");
      if (WR_BYTES < 1 || WR_BYTES > 4)   $error("WR_BYTES must lie in 1..4");
      if (RD_BYTES < 1 || RD_BYTES > 4)   $error("RD_BYTES must lie in 1..4");
   end

   // bundle order: {sdi, sclk, cs_n}; chip select idles high
   logic [2:0] lvl, rise, fall;
   logic       active, sclk_rise, sclk_fall, sdi_s;
   logic       unused_edges;
   logic       byte_valid;
   logic [BYTE_W-1:0] rx_byte;
   logic       tx_load;

   bcp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sdi_i, sclk_i, cs_n_i}),
      .level_o (lvl),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   assign active       = ~lvl[0];
   assign sclk_rise    = rise[1];
   assign sclk_fall    = fall[1];
   assign sdi_s        = lvl[2];
   assign unused_edges = ^{rise[2], rise[0], fall[2], fall[0], lvl[1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sdo_oe_o <= 1'b0;
      else        sdo_oe_o <= active;
   end

   bcp_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (active),
      .strobe_i (sclk_rise),
      .bit_i    (sdi_s),
      .valid_o  (byte_valid),
      .byte_o   (rx_byte)
   );

   bcp_ctrl #(.WR_BYTES(WR_BYTES)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable_i      (active),
      .byte_valid_i  (byte_valid),
      .byte_i        (rx_byte),
      .wr_en_o       (reg_wr_en_o),
      .wr_addr_o     (reg_wr_addr_o),
      .wr_data_o     (reg_wr_data_o),
      .rd_en_o       (reg_rd_en_o),
      .rd_addr_o     (reg_rd_addr_o),
      .tx_load_o     (tx_load),
      .instr_valid_o (instr_valid_o),
      .instr_op_o    (instr_op_o)
   );

   bcp_tx #(.NBYTES(RD_BYTES)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (active),
      .load_i   (tx_load),
      .data_i   (reg_rd_data_i),
      .shift_i  (sclk_fall),
      .sdo_o    (sdo_o)
   );
endmodule

// File: rtl/bcp_checker.sv
module bcp_checker (
   input logic clk,
   input logic rst_n,
   input logic sdo_o,
   input logic sdo_oe_o,
   input logic sclk_fall,
   input logic tx_load,
   input logic reg_wr_en_o,
   input logic reg_rd_en_o,
   input logic instr_valid_o
);
   p_sdo_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe_o |-> !sdo_o);

   p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && $past(sdo_oe_o) && !$past(sclk_fall)) |-> $stable(sdo_o));

   p_fetch_then_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en_o |=> tx_load);

   p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en_o |=> !reg_wr_en_o);

   p_instr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_o |=> !instr_valid_o);

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({reg_wr_en_o, reg_rd_en_o, instr_valid_o}) <= 1);

   p_strobe_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en_o || reg_rd_en_o || instr_valid_o) |-> sdo_oe_o);
endmodule

bind byte_cmd_port bcp_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sdo_o         (sdo_o),
   .sdo_oe_o      (sdo_oe_o),
   .sclk_fall     (sclk_fall),
   .tx_load       (tx_load),
   .reg_wr_en_o   (reg_wr_en_o),
   .reg_rd_en_o   (reg_rd_en_o),
   .instr_valid_o (instr_valid_o)
);

// File: tb/byte_cmd_port_tb.sv
module byte_cmd_port_tb;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic        sdo, sdo_oe, wr_en, rd_en, ins_v;
   logic [4:0]  wr_addr, rd_addr;
   logic [23:0] wr_data, rd_data;
   logic [7:0]  ins_op;

   int checks = 0, errors = 0, cyc = 0;
   string cur_tag = "R1";

   logic [28:0] exp_wr[$];
   logic [4:0]  exp_rd[$];
   logic [7:0]  exp_ins[$];
   bit          exp_sdo[$];
   int          wr_left = 0;
   logic [4:0]  m_wr_addr;
   logic [23:0] m_wr_data;

   always #4 clk = ~clk;

   function automatic logic [23:0] rdata_of(input logic [4:0] a);
      return {3'b101, a, ~a, 3'b011, a ^ 5'h15, 3'b110};
   endfunction

   assign rd_data = rdata_of(rd_addr);

   byte_cmd_port u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe),
      .reg_wr_en_o(wr_en), .reg_wr_addr_o(wr_addr), .reg_wr_data_o(wr_data),
      .reg_rd_en_o(rd_en), .reg_rd_addr_o(rd_addr), .reg_rd_data_i(rd_data),
      .instr_valid_o(ins_v), .instr_op_o(ins_op)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // behavioural model of byte decode
   task automatic model_byte(input logic [7:0] b);
      if (wr_left > 0) begin
         m_wr_data = {m_wr_data[15:0], b};
         wr_left--;
         if (wr_left == 0) exp_wr.push_back({m_wr_addr, m_wr_data});
      end else if (b[7:6] == 2'b00) begin
         logic [23:0] d = rdata_of(b[5:1]);
         exp_rd.push_back(b[5:1]);
         exp_sdo.delete();
         for (int i = 23; i >= 0; i--) exp_sdo.push_back(d[i]);
      end else if (b[7:6] == 2'b01) begin
         wr_left   = 3;
         m_wr_addr = b[5:1];
      end else if (b[7:6] == 2'b11 && b[7:1] != 7'h7F) begin
         exp_ins.push_back(b);
      end
   endtask

   task automatic xfer_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         bit e;
         @(negedge clk);
         sdi = b[7-i];
         repeat (HALF) @(negedge clk);
         e = (exp_sdo.size() > 0) ? exp_sdo.pop_front() : 1'b0;
         check({cur_tag, " sdo"}, sdo, e);
         if (i == 0) check("R9 oe in frame", sdo_oe, 1'b1);
         sclk = 1'b1;
         if (i == 7) model_byte(b);
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] b);
      xfer_bits(b, 8);
   endtask

   task automatic cs_low();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      exp_sdo.delete();
      wr_left = 0;
      repeat (2*HALF) @(negedge clk);
      check("R9 oe off", sdo_oe, 1'b0);
      check("R9 sdo low", sdo, 1'b0);
   endtask

   // strobe comparison on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en) begin
            if (exp_wr.size() == 0) check("R4 unexpected write", {3'b0, wr_addr, wr_data}, 32'hDEAD);
            else check("R4 write", {3'b0, wr_addr, wr_data}, {3'b0, exp_wr.pop_front()});
         end
         if (rd_en) begin
            if (exp_rd.size() == 0) check("R5 unexpected fetch", {27'b0, rd_addr}, 32'hDEAD);
            else check("R5 fetch", {27'b0, rd_addr}, {27'b0, exp_rd.pop_front()});
         end
         if (ins_v) begin
            if (exp_ins.size() == 0) check("R8 unexpected instr", {24'b0, ins_op}, 32'hDEAD);
            else check("R8 instr", {24'b0, ins_op}, {24'b0, exp_ins.pop_front()});
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      check("R1 oe after reset", sdo_oe, 1'b0);
      check("R1 sdo after reset", sdo, 1'b0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      check("R1 oe idle", sdo_oe, 1'b0);

      // R2: bit clock with chip select high must not shift
      for (int i = 0; i < 5; i++) begin
         sdi = i[0];
         repeat (HALF) @(negedge clk); sclk = 1'b1;
         repeat (HALF) @(negedge clk); sclk = 1'b0;
      end
      cs_low();
      cur_tag = "R2";
      xfer(8'hC3);                 // R8 instruction, R2 alignment
      cur_tag = "R7";
      xfer(8'hFE); xfer(8'hFF);    // R7 fillers, no strobe
      cur_tag = "R3";
      xfer(8'h9A);                 // R3 reserved, ignored
      cur_tag = "R4";
      xfer(8'h4B); xfer(8'h12); xfer(8'h34); xfer(8'h56);
      xfer(8'h7E); xfer(8'h00); xfer(8'hFE); xfer(8'hC1);  // R4 payload not decoded
      cur_tag = "R5";
      xfer(8'h0A); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF); xfer(8'hFE);
      cur_tag = "R6";
      xfer(8'h3C); xfer(8'hFF); xfer(8'h12); xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
      cur_tag = "R8";
      xfer(8'h20); xfer(8'hFE); xfer(8'hD7); xfer(8'hFF); xfer(8'hFF);
      cur_tag = "R10";
      xfer(8'h02); xfer(8'h44); xfer(8'hAA); xfer(8'hBB); xfer(8'hCC);
      cur_tag = "R9";
      xfer(8'h06); xfer(8'hFF);
      cs_high();
      cs_low();
      xfer(8'hFF);                 // aborted stream: zeros
      xfer_bits(8'h00, 4);         // partial byte
      cs_high();
      cs_low();
      xfer(8'hC5);                 // R9 counter restarted
      xfer(8'h50); xfer(8'h11);    // partial write
      cs_high();
      cs_low();
      xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
      xfer(8'h50); xfer(8'h77); xfer(8'h88); xfer(8'h99);
      cs_high();

      repeat (40) @(negedge clk);
      check("R4 writes drained", exp_wr.size(), 0);
      check("R5 fetches drained", exp_rd.size(), 0);
      check("R8 instrs drained", exp_ins.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule